// File: doc/BRIEF.md
# Split-Tree Priority Select

This block chooses one data word out of a set of candidates. Each candidate has its own condition bit, and the lowest-indexed true condition wins. Any number of conditions may be true together, and the result is always the same as a first-match scan from index 0 upwards.

A single long chain of priority checks would be as deep as the number of candidates. The block avoids this. It cuts the condition vector into short leaves, and each leaf is resolved by a chain only a few entries deep. Leaf results are then merged pairwise, level by level. At every merge the lower-indexed half is taken if any of its conditions is true; otherwise the upper half is taken. At the top level this means the half holding conditions 0 to 31 is chosen whenever any of those is set. Logic depth therefore grows with the logarithm of the candidate count.

Two outputs are produced: the selected word and a flag that is set when any condition is true. By default the outputs are combinational. A single register stage can be switched on by a parameter.

Top module: `prisel_top`

## Requirements
- R1: The word at index 0 is selected whenever condition 0 is true, whatever the other conditions are; condition i ranks above condition j when i < j.
- R2: For any pattern of conditions, including many true at once, the output equals the data word of the lowest set condition index.
- R3: The hit output equals the OR of all 64 condition bits.
- R4: When no condition is true, the data output is all zeros and hit is 0.
- R5: Whenever any of conditions 0 to 31 is true, the output comes from that lower half, even if upper-half conditions are also set.
- R6: When conditions 0 to 31 are all false, the output is the word of the lowest set condition among 32 to 63.
- R7: Condition 63 alone selects the word at index 63, the last data slice `data_i[64*W-1 -: W]`.
- R8: With the default (unpipelined) setting, the outputs follow the inputs in the same cycle, with no clock edge in between.
- R9: Priority holds across leaf boundaries (default leaf size 4): conditions 3 and 4 together select word 3, and conditions 7 and 8 together select word 7.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, used by the optional output register |
| rst_n | input | 1 | Active-low asynchronous reset |
| cond_i | input | N (64) | Condition bits; bit 0 has the highest priority |
| data_i | input | N*W (1024) | Candidate words; word i occupies bits [i*W +: W] |
| sel_o | output | W (16) | Selected word, zero when nothing matches |
| hit_o | output | 1 | Set when any condition is true |

## Verification
Each condition is first driven alone. This shows that every leaf and every merge path routes its own word to the output, and that none is swapped or shadowed. Paired conditions placed on leaf edges and on the half-way edge (3/4, 7/8, 31/32, 32/63) separate a correct lower-first merge from one that prefers the upper side or mixes up a subtree. The all-ones pattern, the all-upper-half pattern and the empty pattern check the extremes. A long run of dense and sparse pseudo-random patterns is compared against a first-match scan in the bench, to catch overlap errors that the directed cases miss.

// File: rtl/prisel_pkg.sv
package prisel_pkg;

    typedef enum logic {
        PIPE_OFF = 1'b0,
        PIPE_ON  = 1'b1
    } pipe_e;

    function automatic int unsigned tree_nodes(input int unsigned leaves);
        return 2 * leaves - 1;
    endfunction

endpackage

// File: rtl/prisel_leaf.sv
module prisel_leaf #(
    parameter int unsigned LEAF = 4,
    parameter int unsigned W    = 16
) (
    input  logic [LEAF-1:0]   cond_i,
    input  logic [LEAF*W-1:0] data_i,
    output logic              hit_o,
    output logic [W-1:0]      sel_o
);

    // Short chain: scanning downwards leaves the lowest set index as winner.
    always_comb begin
        sel_o = '0;
        hit_o = |cond_i;
        for (int i = LEAF - 1; i >= 0; i--) begin
            if (cond_i[i]) begin
                sel_o = data_i[i*W +: W];
            end
        end
    end

endmodule

// File: rtl/prisel_join.sv
module prisel_join #(
    parameter int unsigned W = 16
) (
    input  logic         lo_hit_i,
    input  logic [W-1:0] lo_data_i,
    input  logic         hi_hit_i,
    input  logic [W-1:0] hi_data_i,
    output logic         hit_o,
    output logic [W-1:0] data_o
);

    // The lower-index subtree outranks the upper one whenever it has any match.
    always_comb begin
        hit_o  = lo_hit_i | hi_hit_i;
        data_o = lo_hit_i ? lo_data_i : hi_data_i;
    end

endmodule

// File: rtl/prisel_tree.sv
module prisel_tree
    import prisel_pkg::*;
#(
    parameter int unsigned N    = 64,
    parameter int unsigned W    = 16,
    parameter int unsigned LEAF = 4
) (
    input  logic [N-1:0]   cond_i,
    input  logic [N*W-1:0] data_i,
    output logic           hit_o,
    output logic [W-1:0]   sel_o
);

    localparam int unsigned NLEAF = N / LEAF;
    localparam int unsigned NODES = tree_nodes(NLEAF);
    localparam int unsigned FIRST = NLEAF - 1;   // heap index of leaf 0

    if ((NLEAF * LEAF != N) || ((NLEAF & (NLEAF - 1)) != 0)) begin : g_bad_cfg
        $error("prisel_tree: N/LEAF must be an integer power of two");
    end

    // Heap layout: node k has children 2k+1 (lower half) and 2k+2 (upper half).
    logic [NODES-1:0] node_hit;
    logic [W-1:0]     node_data [NODES];

    for (genvar k = 0; k < NLEAF; k++) begin : g_leaf
        prisel_leaf #(
            .LEAF (LEAF),
            .W    (W)
        ) u_leaf (
            .cond_i (cond_i[k*LEAF +: LEAF]),
            .data_i (data_i[k*LEAF*W +: LEAF*W]),
            .hit_o  (node_hit[FIRST+k]),
            .sel_o  (node_data[FIRST+k])
        );
    end

    for (genvar n = 0; n < NLEAF - 1; n++) begin : g_join
        prisel_join #(
            .W (W)
        ) u_join (
            .lo_hit_i  (node_hit[2*n+1]),
            .lo_data_i (node_data[2*n+1]),
            .hi_hit_i  (node_hit[2*n+2]),
            .hi_data_i (node_data[2*n+2]),
            .hit_o     (node_hit[n]),
            .data_o    (node_data[n])
        );
    end

    assign hit_o = node_hit[0];
    assign sel_o = node_data[0];

endmodule

// File: rtl/prisel_outreg.sv
module prisel_outreg #(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         hit_i,
    input  logic [W-1:0] data_i,
    output logic         hit_o,
    output logic [W-1:0] data_o
);

    typedef struct packed {
        logic         hit;
        logic [W-1:0] data;
    } stage_t;

    stage_t st_d;
    stage_t st_q;

    always_comb begin
        st_d.hit  = hit_i;
        st_d.data = hit_i ? data_i : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign hit_o  = st_q.hit;
    assign data_o = st_q.data;

endmodule

// File: rtl/prisel_top.sv
module prisel_top
    import prisel_pkg::*;
#(
    parameter int unsigned N    = 64,
    parameter int unsigned W    = 16,
    parameter int unsigned LEAF = 4,
    parameter pipe_e       PIPE = PIPE_OFF
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [N-1:0]   cond_i,
    input  logic [N*W-1:0] data_i,
    output logic [W-1:0]   sel_o,
    output logic           hit_o
);

    localparam int unsigned HALF = N / 2;

    logic         root_hit;
    logic [W-1:0] root_data;

    prisel_tree #(
        .N    (N),
        .W    (W),
        .LEAF (LEAF)
    ) u_tree (
        .cond_i (cond_i),
        .data_i (data_i),
        .hit_o  (root_hit),
        .sel_o  (root_data)
    );

    if (PIPE == PIPE_ON) begin : g_pipe
        prisel_outreg #(
            .W (W)
        ) u_outreg (
            .clk    (clk),
            .rst_n  (rst_n),
            .hit_i  (root_hit),
            .data_i (root_data),
            .hit_o  (hit_o),
            .data_o (sel_o)
        );
    end else begin : g_comb
        assign hit_o = root_hit;
        assign sel_o = root_data;

        AST_HIT_IS_OR: assert property (@(posedge clk) disable iff (!rst_n)
            hit_o == (|cond_i)); // R3

        AST_FIRST_WINS: assert property (@(posedge clk) disable iff (!rst_n)
            cond_i[0] |-> sel_o == data_i[W-1:0]); // R1

        AST_UPPER_WHEN_LOWER_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
            (cond_i[HALF] && !(|cond_i[HALF-1:0])) |-> sel_o == data_i[HALF*W +: W]); // R6

        AST_LAST_ALONE: assert property (@(posedge clk) disable iff (!rst_n)
            (cond_i == {1'b1, {(N-1){1'b0}}}) |-> sel_o == data_i[N*W-1 -: W]); // R7
    end

    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !hit_o |-> sel_o == '0); // R4

endmodule

// File: tb/prisel_top_tb.sv
module prisel_top_tb;

    localparam int unsigned N      = 64;
    localparam int unsigned W      = 16;
    localparam time         PERIOD = 10ns;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [N-1:0]   cond_i = '0;
    logic [N*W-1:0] data_i = '0;
    logic [W-1:0]   sel_o;
    logic           hit_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    prisel_top u_dut (
        .clk    (clk),
        .rst_n  (rst_n),
        .cond_i (cond_i),
        .data_i (data_i),
        .sel_o  (sel_o),
        .hit_o  (hit_o)
    );

    always #(PERIOD/2) clk = ~clk;

    function automatic logic [W-1:0] word(input int i);
        logic [7:0] b = 8'(i);
        return {b ^ 8'h5A, b + 8'hC3};
    endfunction

    // First-match scan from index 0 upwards.
    function automatic logic [W-1:0] ref_sel(input logic [N-1:0] c);
        for (int i = 0; i < N; i++) begin
            if (c[i]) return word(i);
        end
        return '0;
    endfunction

    task automatic chk(input string req, input logic [W-1:0] exp_d, input logic exp_h);
        n_chk++;
        if (sel_o !== exp_d || hit_o !== exp_h) begin
            n_bad++;
            $display("FAIL %s cond=%h sel=%h/%b expected %h/%b",
                     req, cond_i, sel_o, hit_o, exp_d, exp_h);
        end
    endtask

    // Drive on the falling edge, sample 1ns later, well before the next rise.
    task automatic apply(input logic [N-1:0] c);
        @(negedge clk);
        cond_i = c;
        #1ns;
    endtask

    task automatic t_reset;
        cond_i = '0;
        #1ns;
        chk("R4 reset", '0, 1'b0);
        repeat (3) @(posedge clk);
        #1ns;
        rst_n = 1'b1;
        @(negedge clk);
        chk("R4 after reset", '0, 1'b0);
    endtask

    task automatic t_single;
        for (int i = 0; i < N; i++) begin
            apply(64'd1 << i);
            if (i == N - 1) chk("R7 last alone", word(i), 1'b1);
            else if (i == 0) chk("R1 first alone", word(i), 1'b1);
            else chk("R2 single", word(i), 1'b1);
        end
    endtask

    task automatic t_none;
        apply('0);
        chk("R4 none", '0, 1'b0);
        apply({N{1'b1}});
        chk("R1 all set", word(0), 1'b1);
        apply('0);
        chk("R3 cleared", '0, 1'b0);
    endtask

    task automatic t_edges;
        apply((64'd1 << 3) | (64'd1 << 4));
        chk("R9 leaf 3/4", word(3), 1'b1);
        apply((64'd1 << 7) | (64'd1 << 8));
        chk("R9 leaf 7/8", word(7), 1'b1);
        apply((64'd1 << 31) | (64'd1 << 32));
        chk("R5 half 31/32", word(31), 1'b1);
        apply({32'hFFFF_FFFF, 32'h0001_0000});
        chk("R5 lower with upper full", word(16), 1'b1);
        apply((64'd1 << 63) | (64'd1 << 32));
        chk("R6 upper 32/63", word(32), 1'b1);
        apply({32'hFFFF_FFFF, 32'h0});
        chk("R6 upper full", word(32), 1'b1);
        apply({32'h8000_0000, 32'h0});
        chk("R7 last via upper", word(63), 1'b1);
        apply(64'd1 | (64'd1 << 63));
        chk("R1 first over last", word(0), 1'b1);
    endtask

    // Same-cycle response: change inputs twice between rising edges.
    task automatic t_comb;
        @(posedge clk);
        #1ns;
        cond_i = 64'd1 << 40;
        #1ns;
        chk("R8 no edge a", word(40), 1'b1);
        cond_i = 64'd1 << 9;
        #1ns;
        chk("R8 no edge b", word(9), 1'b1);
    endtask

    task automatic t_sweep;
        logic [63:0] s = 64'h9E37_79B9_7F4A_7C15;
        logic [63:0] a;
        for (int k = 0; k < 300; k++) begin
            s ^= s << 13;
            s ^= s >> 7;
            s ^= s << 17;
            a = s;
            if (k % 3 == 1) a = s & (s >> 11) & (s << 5);
            if (k % 3 == 2) a = s & {32'hFFFF_FFFF, 32'h0};
            apply(a);
            chk("R2 sweep", ref_sel(a), |a);
        end
    endtask

    initial begin
        for (int i = 0; i < N; i++) data_i[i*W +: W] = word(i);
        t_reset();
        t_single();
        t_none();
        t_edges();
        t_comb();
        t_sweep();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(PERIOD * 20000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

endmodule